// File: doc/BRIEF.md
# Data-Link Receiver with Automatic HDLC / Bit-Oriented-Message Switching

This block watches the serial data-link bit stream of a framed line and decides by itself which of two kinds of traffic it carries. In packet mode it aligns to HDLC flags and collects whole octets. When a long run of ones appears, it treats the stream as repeated bit-oriented messages. In that mode it takes a 6-bit code out of every 16-bit message pattern. A flag brings it back to packet mode. Either receiver can be switched off. When only one is on, the block stays in that receiver's mode.

Message codes pass through one of three acceptance policies before they are stored. The first stores every well-formed message. The second stores a message only when its code differs from the last stored code. The third stores a code once it wins a vote over the recent well-formed messages. Octets and accepted codes share one receive FIFO. The FIFO has a first-word-fall-through read port and a sticky overflow flag. Bit-stuffing removal and CRC checking are not done here. Only flag detection is part of this block.

Top module: `dl_switch_rx`

## Requirements
- R1: After reset the FIFO is empty (`rdEmpty`=1, `fifoCount`=0), `overflow` is 0 and the block is in packet mode (`inBomMode`=0).
- R2: With both receivers enabled in packet mode, the valid bit that completes a run of 8 consecutive ones switches to message mode, and `inBomMode` is 1 in the next cycle. A run of 7 ones followed by a zero does not switch the mode.
- R3: With both receivers enabled in message mode, a completed flag 01111110 (left bit first) returns the block to packet mode. The bits that follow are aligned as octets from that flag.
- R4: In packet mode with the packet receiver enabled, nothing is stored before the first flag. After a flag, every 8 further bits form one octet, with the first received bit as bit 7. A flag is never stored and re-aligns the octet boundary. When the bit that ends an octet is also the 8th one of a switching run, no octet is stored.
- R5: A message is 8 ones, a 0, six code bits and a stop 0, received in that order. The first code bit goes to bit 5 and the stored byte is {2'b00, code}. A message whose stop bit is 1 is discarded.
- R6: With `bomMode`=0, every well-formed message is stored.
- R7: With `bomMode`=1, a well-formed message is stored only when its code differs from the last stored code, or when no code has been stored yet.
- R8: With `bomMode`=2 or 3, a code is stored when at least 7 of the last 10 well-formed messages (the new one included) carry it and it differs from the last stored code. Discarded messages do not count toward the vote.
- R9: With only `bomEn`=1, the block is in message mode from the next cycle, and flags do not leave it. With only `hdlcEn`=1 it stays in packet mode through any run of ones. With both off, nothing is stored.
- R10: The FIFO holds 64 bytes and returns them in write order. `rdData` shows the oldest byte whenever `rdEmpty`=0, and `rdEn` removes it.
- R11: A write to a full FIFO sets the sticky `overflow` bit. While the bit is set, all writes are dropped. A read clears the bit, and writes after that read are stored again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data-link bit |
| bitValid | input | 1 | Qualifies `bitIn` for one cycle |
| hdlcEn | input | 1 | Packet (HDLC) receiver enable |
| bomEn | input | 1 | Message receiver enable |
| bomMode | input | 2 | Acceptance policy: 0 all, 1 on change, 2/3 vote |
| rdEn | input | 1 | Pops the oldest FIFO byte |
| rdData | output | 8 | Oldest FIFO byte |
| rdEmpty | output | 1 | FIFO holds no data |
| fifoCount | output | 7 | Bytes currently held |
| overflow | output | 1 | Sticky: a write was lost |
| inBomMode | output | 1 | 1 in message mode, 0 in packet mode |

## Verification
The bench uses the default parameters: FIFO depth 64, a switching run of 8 ones, 6-bit codes, and a vote of 7 out of 10. With depth 64, about 66 messages fill the FIFO and push it past full, so the overflow and recovery path runs in a short test. With a vote window of 10, one sequence can show a code accepted on its 7th repetition and not before. The same sequence shows that a malformed repetition in the middle does not move the count.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;

  typedef struct packed {
    logic shift;    // a qualified bit enters the datapath
    logic hdlcWr;   // an aligned packet octet is complete
    logic bomDone;  // a well-formed message has ended
  } dlStrobe_t;

  typedef enum logic [1:0] {
    BOM_EVERY    = 2'd0,
    BOM_ONCHANGE = 2'd1,
    BOM_VOTE     = 2'd2,
    BOM_VOTE_B   = 2'd3
  } bomSel_t;
endpackage

// File: rtl/dlrx_ctrl.sv
module dlrx_ctrl
  import dlrx_pkg::*;
#(
  parameter int RUN_LEN = 8,
  parameter int CODE_W  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitIn,
  input  logic       bitValid,
  input  logic       hdlcEn,
  input  logic       bomEn,
  input  logic       flagNow,
  output dlStrobe_t  strb,
  output logic       inBom
);
  localparam int RUN_W  = $clog2(RUN_LEN + 1);
  localparam int TAIL   = CODE_W + 1;          // code bits plus stop bit
  localparam int TAIL_W = $clog2(TAIL + 1);
  localparam int BCNT_W = $clog2(BYTE_W);

  logic [RUN_W-1:0]  onesRun;
  logic              synced;
  logic [BCNT_W-1:0] byteCnt;
  logic              collecting;
  logic [TAIL_W-1:0] tailCnt;

  logic autoMode, runHit, byteEnd, tailEnd;

  assign autoMode = hdlcEn && bomEn;
  assign runHit   = bitIn && (onesRun >= RUN_W'(RUN_LEN - 1));
  assign byteEnd  = (byteCnt == BCNT_W'(BYTE_W - 1));
  assign tailEnd  = collecting && (tailCnt == TAIL_W'(TAIL - 1));

  always_comb begin
    strb.shift   = bitValid;
    strb.hdlcWr  = bitValid && !inBom && hdlcEn && synced && byteEnd &&
                   !flagNow && !(autoMode && runHit);
    strb.bomDone = bitValid && inBom && bomEn && tailEnd && !bitIn &&
                   !(autoMode && flagNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBom      <= 1'b0;
      onesRun    <= '0;
      synced     <= 1'b0;
      byteCnt    <= '0;
      collecting <= 1'b0;
      tailCnt    <= '0;
    end else begin
      if (!bomEn)       inBom <= 1'b0;
      else if (!hdlcEn) inBom <= 1'b1;

      if (bitValid) begin
        if (bitIn) begin
          if (onesRun != RUN_W'(RUN_LEN)) onesRun <= onesRun + 1'b1;
        end else begin
          onesRun <= '0;
        end

        if (!inBom) begin
          if (autoMode && runHit) begin
            inBom      <= 1'b1;
            synced     <= 1'b0;
            collecting <= 1'b0;
          end else if (flagNow) begin
            synced  <= 1'b1;
            byteCnt <= '0;
          end else if (synced) begin
            byteCnt <= byteCnt + 1'b1;
          end
        end else begin
          if (autoMode && flagNow) begin
            inBom      <= 1'b0;
            synced     <= 1'b1;
            byteCnt    <= '0;
            collecting <= 1'b0;
          end else if (collecting) begin
            if (tailEnd) begin
              collecting <= 1'b0;
              onesRun    <= '0;
            end else begin
              tailCnt <= tailCnt + 1'b1;
            end
          end else if (!bitIn && onesRun == RUN_W'(RUN_LEN)) begin
            collecting <= 1'b1;
            tailCnt    <= '0;
          end
        end
      end
    end
  end

  assert_forced_bom_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bomEn && !hdlcEn) |=> inBom);

  assert_bom_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bomEn |=> !inBom);

  assert_enter_on_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(inBom) && $past(hdlcEn) && $past(bomEn)) |-> $past(bitValid && bitIn));

  assert_leave_on_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(inBom) && $past(bomEn)) |-> $past(flagNow));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.hdlcWr && strb.bomDone));
endmodule

// File: rtl/dlrx_data.sv
module dlrx_data
  import dlrx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int CODE_W     = 6,
  parameter int VOTE_DEPTH = 10,
  parameter int VOTE_NEED  = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         bitIn,
  input  dlStrobe_t                    strb,
  input  logic [1:0]                   bomMode,
  input  logic                         rdEn,
  output logic                         flagNow,
  output logic [BYTE_W-1:0]            rdData,
  output logic                         rdEmpty,
  output logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  output logic                         overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HIST  = VOTE_DEPTH - 1;   // older entries kept beside the new code
  localparam int VC_W  = $clog2(VOTE_DEPTH + 1);

  // bit window
  logic [BYTE_W-2:0] sr;
  logic [BYTE_W-1:0] srNext;
  assign srNext  = {sr, bitIn};
  assign flagNow = strb.shift && (srNext == FLAG_PAT);

  always_ff @(posedge clk) begin
    if (!rstN)           sr <= '0;
    else if (strb.shift) sr <= srNext[BYTE_W-2:0];
  end

  logic [CODE_W-1:0] code;
  assign code = srNext[CODE_W:1];

  // vote history of well-formed codes
  logic [CODE_W-1:0]     hist [HIST];
  logic [HIST-1:0]       histVld;
  logic [VOTE_DEPTH-1:0] hit;
  logic [VC_W-1:0]       voteCnt;

  assign hit[0] = 1'b1;
  for (genvar g = 1; g < VOTE_DEPTH; g++) begin : gVote
    assign hit[g] = histVld[g-1] && (hist[g-1] == code);
  end
  assign voteCnt = VC_W'($countones(hit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histVld <= '0;
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else if (strb.bomDone) begin
      hist[0]    <= code;
      histVld[0] <= 1'b1;
      for (int i = 1; i < HIST; i++) begin
        hist[i]    <= hist[i-1];
        histVld[i] <= histVld[i-1];
      end
    end
  end

  // acceptance policy
  logic [CODE_W-1:0] lastCode;
  logic              lastVld;
  logic              isNew, accept, bomWr;

  assign isNew = !lastVld || (code != lastCode);

  always_comb begin
    unique case (bomSel_t'(bomMode))
      BOM_EVERY:    accept = 1'b1;
      BOM_ONCHANGE: accept = isNew;
      BOM_VOTE,
      BOM_VOTE_B:   accept = isNew && (voteCnt >= VC_W'(VOTE_NEED));
      default:      accept = 1'b0;
    endcase
  end
  assign bomWr = strb.bomDone && accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCode <= '0;
      lastVld  <= 1'b0;
    end else if (bomWr) begin
      lastCode <= code;
      lastVld  <= 1'b1;
    end
  end

  // receive FIFO
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              wrReq, full, doRead, doWrite;
  logic [BYTE_W-1:0] wrData;

  assign wrReq   = strb.hdlcWr || bomWr;
  assign wrData  = strb.hdlcWr ? srNext : BYTE_W'(code);
  assign full    = (fifoCount == CNT_W'(DEPTH));
  assign rdEmpty = (fifoCount == '0);
  assign rdData  = mem[rdPtr];
  assign doRead  = rdEn && !rdEmpty;
  assign doWrite = wrReq && !overflow && (!full || doRead);

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      overflow  <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + 1'b1;
      if (doRead)  rdPtr <= rdPtr + 1'b1;
      if (doWrite && !doRead)      fifoCount <= fifoCount + 1'b1;
      else if (doRead && !doWrite) fifoCount <= fifoCount - 1'b1;
      if (doRead)                       overflow <= 1'b0;
      else if (wrReq && !doWrite)       overflow <= 1'b1;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoCount) <= DEPTH);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fifoCount) == int'($past(fifoCount))) ||
    (int'(fifoCount) == int'($past(fifoCount)) + 1) ||
    (int'(fifoCount) + 1 == int'($past(fifoCount))));

  assert_overflow_from_full_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> (int'($past(fifoCount)) == DEPTH));

  assert_no_write_blocked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !rdEn) |=> (fifoCount <= $past(fifoCount)));
endmodule

// File: rtl/dl_switch_rx.sv
module dl_switch_rx
  import dlrx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int RUN_LEN    = 8,
  parameter int CODE_W     = 6,
  parameter int VOTE_DEPTH = 10,
  parameter int VOTE_NEED  = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        bitIn,
  input  logic                        bitValid,
  input  logic                        hdlcEn,
  input  logic                        bomEn,
  input  logic [1:0]                  bomMode,
  input  logic                        rdEn,
  output logic [7:0]                  rdData,
  output logic                        rdEmpty,
  output logic [$clog2(DEPTH+1)-1:0]  fifoCount,
  output logic                        overflow,
  output logic                        inBomMode
);
  dlStrobe_t strb;
  logic      flagNow;

  dlrx_ctrl #(.RUN_LEN(RUN_LEN), .CODE_W(CODE_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitIn    (bitIn),
    .bitValid (bitValid),
    .hdlcEn   (hdlcEn),
    .bomEn    (bomEn),
    .flagNow  (flagNow),
    .strb     (strb),
    .inBom    (inBomMode)
  );

  dlrx_data #(.DEPTH(DEPTH), .CODE_W(CODE_W), .VOTE_DEPTH(VOTE_DEPTH),
              .VOTE_NEED(VOTE_NEED)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .strb      (strb),
    .bomMode   (bomMode),
    .rdEn      (rdEn),
    .flagNow   (flagNow),
    .rdData    (rdData),
    .rdEmpty   (rdEmpty),
    .fifoCount (fifoCount),
    .overflow  (overflow)
  );
endmodule

// File: tb/tb_dl_switch_rx.sv
`timescale 1ns/1ps
module tb_dl_switch_rx;
  logic       clk = 1'b0;
  logic       rstN;
  logic       bitIn, bitValid, hdlcEn, bomEn, rdEn;
  logic [1:0] bomMode;
  logic [7:0] rdData;
  logic       rdEmpty, overflow, inBomMode;
  logic [6:0] fifoCount;

  int checks = 0;
  int fails  = 0;
  logic monEn = 1'b0;
  logic [7:0] sbQ [$];

  always #2 clk = ~clk;

  dl_switch_rx dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .hdlcEn(hdlcEn), .bomEn(bomEn), .bomMode(bomMode), .rdEn(rdEn),
    .rdData(rdData), .rdEmpty(rdEmpty), .fifoCount(fifoCount),
    .overflow(overflow), .inBomMode(inBomMode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops stored bytes and compares with the scoreboard (R10)
  always @(negedge clk) begin
    if (monEn && rstN && !rdEmpty) begin
      checks++;
      if (sbQ.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected byte actual %0h expected none", rdData);
      end else begin
        logic [7:0] e;
        e = sbQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL R10: actual %0h expected %0h", rdData, e);
        end
      end
      rdEn = 1'b1;
    end else begin
      rdEn = 1'b0;
    end
  end

  task automatic sendBit(input logic b);
    bitIn = b; bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
  endtask
  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask
  task automatic sendOnes(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask
  task automatic sendTail(input logic [5:0] c, input logic good);
    sendBit(1'b0);
    for (int i = 5; i >= 0; i--) sendBit(c[i]);
    sendBit(good ? 1'b0 : 1'b1);
  endtask
  task automatic sendBom(input logic [5:0] c, input logic good);
    sendOnes(8);
    sendTail(c, good);
  endtask
  task automatic push(input logic [7:0] v);
    sbQ.push_back(v);
  endtask
  task automatic drain();
    for (int i = 0; i < 4000 && (sbQ.size() != 0 || !rdEmpty); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; bitIn = 1'b0; bitValid = 1'b0; hdlcEn = 1'b1; bomEn = 1'b1;
    bomMode = 2'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", rdEmpty, 1);
    chk("R1 count", fifoCount, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 mode", inBomMode, 0);
    monEn = 1'b1;

    // R2 negative: 7 ones do not switch; R4: nothing stored before a flag
    sendOnes(7); sendBit(1'b0);
    chk("R2 seven ones", inBomMode, 0);
    sendByte(8'h7E);
    push(8'hA5); sendByte(8'hA5);
    push(8'h3C); sendByte(8'h3C);
    sendByte(8'h7E);                          // R4 flag not stored
    sendOnes(8);
    chk("R2 eight ones", inBomMode, 1);
    drain();
    chk("R4 octets", sbQ.size(), 0);

    // R5/R6 every well-formed message stored, broken one dropped
    push(8'h15); sendTail(6'h15, 1'b1);
    push(8'h15); sendBom(6'h15, 1'b1);
    push(8'h2A); sendBom(6'h2A, 1'b1);
    sendBom(6'h0C, 1'b0);                     // R5 bad stop bit
    push(8'h0C); sendBom(6'h0C, 1'b1);
    drain();
    chk("R6 all stored", sbQ.size(), 0);

    // R7 store on change
    bomMode = 2'd1;
    push(8'h15); sendBom(6'h15, 1'b1);
    sendBom(6'h15, 1'b1);
    push(8'h2A); sendBom(6'h2A, 1'b1);
    sendBom(6'h2A, 1'b1);
    push(8'h15); sendBom(6'h15, 1'b1);
    drain();
    chk("R7 on change", sbQ.size(), 0);

    // R8 vote 7 of 10
    bomMode = 2'd2;
    for (int i = 0; i < 6; i++) sendBom(6'h07, 1'b1);
    drain();
    chk("R8 six votes not stored", rdEmpty, 1);
    push(8'h07); sendBom(6'h07, 1'b1);
    for (int i = 0; i < 3; i++) sendBom(6'h07, 1'b1);
    bomMode = 2'd3;
    for (int i = 0; i < 6; i++) sendBom(6'h33, 1'b1);
    sendBom(6'h33, 1'b0);                     // R8 broken frame not counted
    drain();
    chk("R8 broken not counted", sbQ.size() + (rdEmpty ? 0 : 1), 0);
    push(8'h33); sendBom(6'h33, 1'b1);
    drain();
    chk("R8 seventh vote", sbQ.size(), 0);

    // R3 flag returns to packet mode, octets aligned to it
    sendByte(8'h7E);
    chk("R3 back to packet", inBomMode, 0);
    push(8'h5A); sendByte(8'h5A);
    drain();
    chk("R3 aligned octet", sbQ.size(), 0);

    // R9 packet receiver only: ones do not switch
    hdlcEn = 1'b1; bomEn = 1'b0;
    sendByte(8'h7E);
    push(8'hFF); sendOnes(8);
    chk("R9 packet only stays", inBomMode, 0);
    drain();
    chk("R9 packet only byte", sbQ.size(), 0);

    // R9 message receiver only
    hdlcEn = 1'b0; bomEn = 1'b1;
    @(negedge clk);
    chk("R9 forced message mode", inBomMode, 1);
    bomMode = 2'd0;
    push(8'h21); sendBom(6'h21, 1'b1);
    sendByte(8'h7E);
    chk("R9 flag ignored", inBomMode, 1);
    drain();

    // R9 both off
    hdlcEn = 1'b0; bomEn = 1'b0;
    sendByte(8'h7E); sendByte(8'h5A); sendBom(6'h11, 1'b1);
    drain();
    chk("R9 both off mode", inBomMode, 0);
    chk("R9 both off empty", rdEmpty, 1);

    // R10/R11 fill past full
    monEn = 1'b0;
    bomEn = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 66; i++) begin
      if (i < 64) push(8'(i % 48));
      sendBom(6'(i % 48), 1'b1);
    end
    repeat (2) @(negedge clk);
    chk("R10 depth", fifoCount, 64);
    chk("R11 overflow set", overflow, 1);
    monEn = 1'b1;
    drain();
    chk("R11 overflow cleared", overflow, 0);
    chk("R10 drained", fifoCount, 0);
    push(8'h05); sendBom(6'h05, 1'b1);
    drain();
    chk("R11 writes resume", sbQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule